// File: doc/BRIEF.md
# Video Illegal Code Remapper

This block sits in a 10-bit video word stream and removes code values that are reserved for synchronisation. Inside the active picture it clamps such values to the nearest legal level. It also finds timing and ancillary preambles written in 8-bit style, where only the upper eight bits carry meaning, and rewrites them to exact 10-bit codes. The upstream logic supplies a flag that marks active picture words. The block has no line or pixel counters and does not decode timing words beyond matching the preamble shapes.

Words enter through a valid strobe. A short delay line holds the two most recent words, so a three-word preamble can be seen before its first word leaves. Every word reaches the output after a fixed number of accepted beats, whether or not it was changed. A single control input, `remap_dis`, turns off all rewriting and clamping when it is high.

Top module: `video_code_remap`

## Requirements
- R1: With `remap_dis` low, an active picture word in 3FCh..3FFh that is not part of a preamble is output as 3FBh.
- R2: With `remap_dis` low, an active picture word in 000h..003h that is not part of a preamble is output as 004h.
- R3: A word with `in_active` low that is not part of a preamble is output unchanged.
- R4: With `remap_dis` high at the beats where a word is processed, the word is output unchanged, preamble shapes included.
- R5: With `remap_dis` low, three consecutive accepted words in the bands (3FCh..3FFh, 000h..003h, 000h..003h) are output as 3FFh, 000h, 000h.
- R6: With `remap_dis` low, three consecutive accepted words in the bands (000h..003h, 3FCh..3FFh, 3FCh..3FFh) are output as 000h, 3FFh, 3FFh.
- R7: Preamble members are never clamped to 004h or 3FBh, even when `in_active` is high.
- R8: A word accepted on valid beat n appears on `out_word`, with `out_valid` high, in the cycle after valid beat n+2. `out_valid` is high for exactly one cycle per such beat.
- R9: In a cycle with `in_valid` low, the stored words do not change, and `out_valid` is low in the following cycle.
- R10: While `rst` is high, and during the first two accepted beats after reset, `out_valid` stays low.
- R11: Words in 004h..3FBh are output unchanged unless they belong to a preamble, which cannot happen for these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new word is present on `in_word` |
| in_word | input | 10 | Incoming video word |
| in_active | input | 1 | The incoming word lies in the active picture |
| remap_dis | input | 1 | High: pass words through untouched; low: clamp and rewrite |
| out_valid | output | 1 | `out_word` carries a word in this cycle |
| out_word | output | 10 | Corrected video word |

## Verification
A stored slot that holds a wrong word, flag or preamble mark shows up at `out_word` within two accepted beats, when that slot reaches the output register. A lost fill bit shows up sooner, as an `out_valid` pulse too early or too late after reset. Wrong preamble detection changes three consecutive output words, and wrong clamping changes one, so every fault shows in the word sequence at a known beat. Random streams with many reserved codes and injected preambles, both inside and outside the active picture, reach these states. Bubbles in `in_valid` check that the delay line holds its contents.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WORD_W = 10;
    localparam int BAND_W = 2;   // low bits ignored by 8-bit style codes

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t CODE_HI        = {WORD_W{1'b1}};
    localparam word_t CODE_LO        = '0;
    localparam word_t LEGAL_CEIL     = CODE_HI - word_t'((1 << BAND_W));
    localparam word_t LEGAL_FLOOR    = word_t'((1 << BAND_W));

    typedef enum logic [1:0] {
        PRE_NONE   = 2'd0,
        PRE_TIMING = 2'd1,
        PRE_ANC    = 2'd2
    } pre_kind_e;

    typedef struct packed {
        word_t word;
        logic  act;
        logic  pre;
        logic  vld;
    } slot_t;

    function automatic logic in_hi_band(word_t w);
        return w[WORD_W-1:BAND_W] == {(WORD_W-BAND_W){1'b1}};
    endfunction

    function automatic logic in_lo_band(word_t w);
        return w[WORD_W-1:BAND_W] == '0;
    endfunction
endpackage

// File: rtl/vcr_preamble_detect.sv
module vcr_preamble_detect
    import vcr_pkg::*;
(
    input  word_t     oldest,
    input  word_t     middle,
    input  word_t     newest,
    input  logic      armed,
    output pre_kind_e kind,
    output word_t     fix_old,
    output word_t     fix_mid,
    output word_t     fix_new
);
    timeunit 1ns;
    timeprecision 1ps;

    logic timing_shape;
    logic anc_shape;

    always_comb begin
        timing_shape = in_hi_band(oldest) && in_lo_band(middle) && in_lo_band(newest);
        anc_shape    = in_lo_band(oldest) && in_hi_band(middle) && in_hi_band(newest);
        kind    = PRE_NONE;
        fix_old = oldest;
        fix_mid = middle;
        fix_new = newest;
        if (armed && timing_shape) begin
            kind    = PRE_TIMING;
            fix_old = CODE_HI;
            fix_mid = CODE_LO;
            fix_new = CODE_LO;
        end else if (armed && anc_shape) begin
            kind    = PRE_ANC;
            fix_old = CODE_LO;
            fix_mid = CODE_HI;
            fix_new = CODE_HI;
        end
    end
endmodule

// File: rtl/vcr_code_clamp.sv
module vcr_code_clamp
    import vcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  act,
    input  logic  pre,
    input  word_t word_i,
    output word_t word_o
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        word_o = word_i;
        if (en && act && !pre) begin
            if (in_hi_band(word_i))
                word_o = LEGAL_CEIL;
            else if (in_lo_band(word_i))
                word_o = LEGAL_FLOOR;
        end
    end

    // R1 R2
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (en && act && !pre) |-> (word_o >= LEGAL_FLOOR && word_o <= LEGAL_CEIL));

    // R3
    blank_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!act && !pre) |-> (word_o == word_i));
endmodule

// File: rtl/video_code_remap.sv
module video_code_remap
    import vcr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                in_active,
    input  logic                remap_dis,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SLOTS = 2;   // held words ahead of the output register

    slot_t     slot_q [SLOTS];  // index 0 newest, SLOTS-1 oldest
    slot_t     leave_s;
    slot_t     shift_s [SLOTS];
    pre_kind_e kind;
    word_t     fix_old, fix_mid, fix_new;
    word_t     clamped;
    logic      en, hit, emit;

    assign en   = !remap_dis;
    assign emit = in_valid && slot_q[SLOTS-1].vld;

    vcr_preamble_detect u_detect (
        .oldest  (slot_q[1].word),
        .middle  (slot_q[0].word),
        .newest  (in_word),
        .armed   (en && slot_q[1].vld && slot_q[0].vld),
        .kind    (kind),
        .fix_old (fix_old),
        .fix_mid (fix_mid),
        .fix_new (fix_new)
    );

    assign hit = (kind != PRE_NONE);

    always_comb begin
        leave_s      = slot_q[1];
        leave_s.word = fix_old;
        leave_s.pre  = slot_q[1].pre || hit;

        shift_s[0]      = '{word: fix_new, act: in_active, pre: hit, vld: 1'b1};
        shift_s[1]      = slot_q[0];
        shift_s[1].word = fix_mid;
        shift_s[1].pre  = slot_q[0].pre || hit;
    end

    vcr_code_clamp u_clamp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .act    (leave_s.act),
        .pre    (leave_s.pre),
        .word_i (leave_s.word),
        .word_o (clamped)
    );

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[gi] <= '0;
            else if (in_valid)
                slot_q[gi] <= shift_s[gi];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= emit;
            if (emit)
                out_word <= clamped;
        end
    end

    // R10
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R9
    bubble_novalid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(slot_q[0]) && $stable(slot_q[1])));

    // R4
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && remap_dis && slot_q[1].vld && !slot_q[1].pre)
        |=> (out_valid && out_word == $past(slot_q[1].word)));

    // R5
    timing_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == PRE_TIMING)
        |=> (out_valid && out_word == CODE_HI && slot_q[1].word == CODE_LO
             && slot_q[0].word == CODE_LO));

    // R6
    anc_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == PRE_ANC)
        |=> (out_valid && out_word == CODE_LO && slot_q[1].word == CODE_HI
             && slot_q[0].word == CODE_HI));
endmodule

// File: tb/video_code_remap_tb.sv
module video_code_remap_tb_top;
    timeunit 1ns;
    timeprecision 1ps;
    import vcr_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  in_valid = 1'b0;
    word_t in_word = '0;
    logic  in_active = 1'b0;
    logic  remap_dis = 1'b0;
    logic  out_valid;
    word_t out_word;

    int n_cmp = 0;
    int n_bad = 0;

    word_t mw [8192];
    logic  ma [8192];
    int    mk [8192];
    int    cnt = 0;
    logic  exp_vld;
    word_t exp_word;
    string exp_tag;

    always #2.5 clk = ~clk;

    video_code_remap dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_active (in_active),
        .remap_dis (remap_dis),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic hi(word_t w);
        return w >= 10'h3FC;
    endfunction

    function automatic logic lo(word_t w);
        return w <= 10'h003;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        cnt = 0;
    endtask

    // model of the requirements, evaluated for the coming clock edge
    task automatic model_accept(word_t w, logic a);
        logic en = !remap_dis;
        int   j;
        mw[cnt] = w; ma[cnt] = a; mk[cnt] = 0;
        if (en && cnt >= 2) begin
            if (hi(mw[cnt-2]) && lo(mw[cnt-1]) && lo(w)) begin
                mw[cnt-2] = 10'h3FF; mw[cnt-1] = 10'h000; mw[cnt] = 10'h000;
                mk[cnt-2] = 1; mk[cnt-1] = 1; mk[cnt] = 1;
            end else if (lo(mw[cnt-2]) && hi(mw[cnt-1]) && hi(w)) begin
                mw[cnt-2] = 10'h000; mw[cnt-1] = 10'h3FF; mw[cnt] = 10'h3FF;
                mk[cnt-2] = 2; mk[cnt-1] = 2; mk[cnt] = 2;
            end
        end
        if (cnt >= 2) begin
            j = cnt - 2;
            exp_vld = 1'b1;
            exp_word = mw[j];
            if (mk[j] == 1)
                exp_tag = ma[j] ? "R5 R7 timing preamble in picture" : "R5 timing preamble";
            else if (mk[j] == 2)
                exp_tag = ma[j] ? "R6 R7 anc preamble in picture" : "R6 anc preamble";
            else if (!en)
                exp_tag = "R4 bypass";
            else if (!ma[j])
                exp_tag = "R3 blanking pass";
            else if (hi(mw[j])) begin
                exp_tag = "R1 high clamp"; exp_word = 10'h3FB;
            end else if (lo(mw[j])) begin
                exp_tag = "R2 low clamp"; exp_word = 10'h004;
            end else
                exp_tag = "R11 legal word";
        end else begin
            exp_vld = 1'b0;
            exp_tag = "R10 warm-up";
        end
        cnt++;
    endtask

    task automatic step(logic v, word_t w, logic a);
        in_valid = v; in_word = w; in_active = a;
        if (v)
            model_accept(w, a);
        else begin
            exp_vld = 1'b0;
            exp_tag = "R9 bubble";
        end
        @(negedge clk);
        chk({"R8 valid ", exp_tag}, out_valid, exp_vld);
        if (exp_vld)
            chk(exp_tag, out_word, exp_word);
    endtask

    function automatic word_t pick();
        int unsigned r = $urandom % 8;
        if (r < 2) return word_t'(10'h3FC + ($urandom % 4));
        if (r < 4) return word_t'($urandom % 4);
        return word_t'($urandom % 1024);
    endfunction

    task automatic directed_set();
        step(1, 10'h3FD, 1);
        step(1, 10'h100, 1);
        step(1, 10'h000, 1);
        step(1, 10'h200, 1);
        step(1, 10'h3FE, 0);
        step(0, 10'h155, 1);
        step(1, 10'h3FC, 1);
        step(0, 10'h2AA, 0);
        step(1, 10'h001, 1);
        step(1, 10'h002, 1);
        step(1, 10'h150, 1);
        step(1, 10'h002, 1);
        step(1, 10'h3FE, 1);
        step(1, 10'h3FD, 1);
        step(1, 10'h160, 0);
        step(1, 10'h3FF, 0);
        step(1, 10'h000, 0);
        step(1, 10'h003, 0);
        for (int k = 0; k < 3; k++) step(1, 10'h180, 1);
    endtask

    task automatic run_random(int beats, logic dis);
        remap_dis = dis;
        for (int k = 0; k < beats; k++) begin
            if ($urandom % 10 == 0) begin
                if ($urandom % 2 == 0) begin
                    step(1, word_t'(10'h3FC + ($urandom % 4)), 1'($urandom % 2));
                    step(1, word_t'($urandom % 4), 1'($urandom % 2));
                    step(1, word_t'($urandom % 4), 1'($urandom % 2));
                end else begin
                    step(1, word_t'($urandom % 4), 1'($urandom % 2));
                    step(1, word_t'(10'h3FC + ($urandom % 4)), 1'($urandom % 2));
                    step(1, word_t'(10'h3FC + ($urandom % 4)), 1'($urandom % 2));
                end
            end else
                step(($urandom % 4) != 0, pick(), 1'($urandom % 2));
        end
    endtask

    initial begin
        #(200000 * 5.0);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005EED1));
        remap_dis = 1'b0;
        do_reset();
        directed_set();
        remap_dis = 1'b1;
        do_reset();
        directed_set();
        remap_dis = 1'b0;
        do_reset();
        run_random(2000, 1'b0);
        do_reset();
        run_random(1000, 1'b1);
        run_random(1500, 1'b0);
        do_reset();
        for (int k = 0; k < 8; k++) run_random(200, 1'($urandom % 2));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule